// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit up-counting timer meant to give an operating system its periodic tick. The count is advanced by a selectable input: the system clock, the system clock divided by sixteen, or a rising edge on an external clock pin. An 8-bit prescaler sits between that input and the counter. When the counter reaches the value held in a reference register, a match event is latched and an interrupt can be raised. The counter can restart at zero after a match or run on and wrap.

Software drives the block through a small 16-bit register port with four word addresses: mode, reference, counter and event. Writes take effect at the clock edge where the write strobe is high, and reads return data on the same cycle. A typical tick setup stops the timer, loads the reference, clears the events and then writes the mode with the restart and interrupt-enable bits set. The interrupt service routine then clears the match flag by writing a one to it.

Top module: `prc_timer`

## Requirements
- R1: After synchronous reset all four registers read 0x0000 and `irq` is low.
- R2: Address 0 is the mode register and address 1 the reference register; both read back exactly the 16-bit value last written, including the capture-edge bits [7:6] and output-mode bit [5], which are stored but have no effect.
- R3: Mode bits [2:1] select the count source: 0 gives no ticks, 1 gives one tick per system clock, 2 gives one tick per 16 system clocks, and 3 gives one tick per rising edge of `ext_clk_in`, seen by the counter within four clocks of the edge.
- R4: Mode bits [15:8] hold the prescale value P; the counter advances once for every P+1 source ticks.
- R5: While mode bit [0] (run) is 0, the counter and prescaler are held at zero. Counting begins on the first source tick after run is set.
- R6: With mode bit [3] (restart) set, a count tick taken while the counter equals the reference returns it to 0. With restart clear, the counter keeps counting and wraps from 0xFFFF to 0x0000.
- R7: On the count tick that brings the counter to the reference value, event bit 1 is set if mode bit [4] (match interrupt enable) is 1. It is not set if that bit is 0.
- R8: Event bits clear when a 1 is written to them at address 3. Writing 0 to a bit leaves it as it was, and a hardware set in the same cycle as a clear wins.
- R9: `irq` is high exactly while event bit 1 is set and mode bit [4] is 1, and it stays high until software clears the flag or the enable.
- R10: Any write to address 2 forces the counter and prescaler to zero, whatever the data.
- R11: Address 3 reads {14'b0, match flag, capture flag}; the capture flag (bit 0) is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register word address: 0 mode, 1 reference, 2 counter, 3 event |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ext_clk_in | input | 1 | External count clock, asynchronous, synchronized inside |
| irq | output | 1 | Match interrupt, level |

## Verification
The embedded properties assume that `ext_clk_in` holds each level for at least two system clocks, so the synchronizer sees every edge, and that every register access is a single-cycle strobe with a stable address. They also assume that software changes the prescale or reference only while the timer is stopped, or else accepts one irregular period. The stimulus holds the external clock for three cycles per level, reconfigures only after writing run to 0, and chooses random non-zero reference values. In non-restart runs it keeps the number of ticks below the wrap point, so every expected count and flag follows directly from the tick count.

// File: rtl/prc_timer_pkg.sv
package prc_timer_pkg;

    localparam int TMR_W = 16;
    localparam int PS_W  = 8;
    localparam int EVT_N = 2;

    localparam int EVT_CAP_BIT = 0;
    localparam int EVT_REF_BIT = 1;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_EXT   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        ADR_MODE = 2'd0,
        ADR_REF  = 2'd1,
        ADR_CNT  = 2'd2,
        ADR_EVT  = 2'd3
    } reg_adr_e;

    // Field order defines the bit positions: [15:8] .. [0]
    typedef struct packed {
        logic [PS_W-1:0] prescale;
        logic [1:0]      cap_edge;
        logic            out_mode;
        logic            ref_ie;
        logic            restart;
        clk_src_e        src;
        logic            run;
    } mode_t;

    function automatic logic [TMR_W-1:0] evt_word(input logic [EVT_N-1:0] f);
        logic [TMR_W-1:0] w;
        w = '0;
        w[EVT_N-1:0] = f;
        return w;
    endfunction

endpackage

// File: rtl/prc_tmr_src.sv
module prc_tmr_src
    import prc_timer_pkg::*;
#(
    parameter int DIV_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     ext_in,
    output logic     src_tick
);
    logic [DIV_W-1:0] div_q;
    logic [SYNC_N:0]  sync_q;
    logic             div_tick;
    logic             ext_rise;

    always_ff @(posedge clk) begin
        if (rst || !run || src != SRC_DIV16) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign div_tick = &div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], ext_in};
        end
    end

    assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    always_comb begin
        src_tick = 1'b0;
        if (run) begin
            unique case (src)
                SRC_OFF:   src_tick = 1'b0;
                SRC_SYS:   src_tick = 1'b1;
                SRC_DIV16: src_tick = div_tick;
                SRC_EXT:   src_tick = ext_rise;
                default:   src_tick = 1'b0;
            endcase
        end
    end

    // R3
    src_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_OFF) |-> !src_tick);

endmodule

// File: rtl/prc_tmr_prescale.sv
module prc_tmr_prescale #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clear,
    input  logic            src_tick,
    input  logic [PS_W-1:0] ratio_m1,
    output logic            cnt_tick
);
    logic [PS_W-1:0] pre_q;
    logic            wrap;

    assign wrap     = (pre_q >= ratio_m1);
    assign cnt_tick = run && !clear && src_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run || clear) begin
            pre_q <= '0;
        end else if (src_tick) begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
    end

    // R4
    no_tick_without_src_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |-> src_tick);

endmodule

// File: rtl/prc_tmr_counter.sv
module prc_tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clear,
    input  logic         cnt_tick,
    input  logic         restart,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] count,
    output logic         ref_hit
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    assign cnt_nxt = (restart && cnt_q == ref_val) ? '0 : cnt_q + 1'b1;
    assign ref_hit = cnt_tick && run && !clear && (cnt_nxt == ref_val);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || clear) begin
            cnt_q <= '0;
        end else if (cnt_tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    // R5
    stopped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && !cnt_tick) |=> $stable(count));

    // R6
    restart_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && cnt_tick && restart && count == ref_val) |=> (count == '0));

    // R10
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

endmodule

// File: rtl/prc_tmr_events.sv
module prc_tmr_events
    import prc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] set_v,
    input  logic [EVT_N-1:0] clr_v,
    input  logic [EVT_N-1:0] ie_v,
    output logic [EVT_N-1:0] flags,
    output logic             irq
);
    logic [EVT_N-1:0] flag_q;

    for (genvar i = 0; i < EVT_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set_v[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_v[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & ie_v);

    // R7
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        set_v[EVT_REF_BIT] |=> flags[EVT_REF_BIT]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[EVT_REF_BIT] && !clr_v[EVT_REF_BIT]) |=> flags[EVT_REF_BIT]);

endmodule

// File: rtl/prc_timer.sv
module prc_timer
    import prc_timer_pkg::*;
#(
    parameter int DIV_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [TMR_W-1:0] reg_wdata,
    output logic [TMR_W-1:0] reg_rdata,
    input  logic             ext_clk_in,
    output logic             irq
);
    mode_t            mode_q;
    logic [TMR_W-1:0] ref_q;
    logic [TMR_W-1:0] count;
    logic [EVT_N-1:0] flags;
    logic [EVT_N-1:0] set_v;
    logic [EVT_N-1:0] clr_v;
    logic [EVT_N-1:0] ie_v;
    logic             wr_mode, wr_ref, wr_cnt, wr_evt;
    logic             src_tick, cnt_tick, ref_hit;

    assign wr_mode = reg_we && (reg_adr_e'(reg_addr) == ADR_MODE);
    assign wr_ref  = reg_we && (reg_adr_e'(reg_addr) == ADR_REF);
    assign wr_cnt  = reg_we && (reg_adr_e'(reg_addr) == ADR_CNT);
    assign wr_evt  = reg_we && (reg_adr_e'(reg_addr) == ADR_EVT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ref_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= mode_t'(reg_wdata);
            if (wr_ref)  ref_q  <= reg_wdata;
        end
    end

    prc_tmr_src #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_src (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .src      (mode_q.src),
        .ext_in   (ext_clk_in),
        .src_tick (src_tick)
    );

    prc_tmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .clear    (wr_cnt),
        .src_tick (src_tick),
        .ratio_m1 (mode_q.prescale),
        .cnt_tick (cnt_tick)
    );

    prc_tmr_counter #(.W(TMR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .clear    (wr_cnt),
        .cnt_tick (cnt_tick),
        .restart  (mode_q.restart),
        .ref_val  (ref_q),
        .count    (count),
        .ref_hit  (ref_hit)
    );

    always_comb begin
        set_v = '0;
        ie_v  = '0;
        set_v[EVT_REF_BIT] = ref_hit && mode_q.ref_ie;
        ie_v[EVT_REF_BIT]  = mode_q.ref_ie;
        clr_v = wr_evt ? reg_wdata[EVT_N-1:0] : '0;
    end

    prc_tmr_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .ie_v  (ie_v),
        .flags (flags),
        .irq   (irq)
    );

    always_comb begin
        unique case (reg_adr_e'(reg_addr))
            ADR_MODE: reg_rdata = mode_q;
            ADR_REF:  reg_rdata = ref_q;
            ADR_CNT:  reg_rdata = count;
            ADR_EVT:  reg_rdata = evt_word(flags);
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    irq_drop_by_sw_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(reg_we));

    // R11
    cap_flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !flags[EVT_CAP_BIT]);

endmodule

// File: tb/test_prc_timer.sv
module test_prc_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ext_clk_in = 1'b0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prc_timer i_prc_timer (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ext_clk_in (ext_clk_in),
        .irq        (irq)
    );

    localparam logic [1:0] A_MODE = 2'd0, A_REF = 2'd1, A_CNT = 2'd2, A_EVT = 2'd3;

    function automatic logic [15:0] mk_mode(input int ps, input bit ie,
                                            input bit rs, input int src, input bit run);
        return {ps[7:0], 2'b00, 1'b0, ie, rs, src[1:0], run};
    endfunction

    function automatic int exp_ticks(input int src, input int ps, input int n);
        int s;
        s = (src == 1) ? n : (src == 2) ? n / 16 : 0;
        return s / (ps + 1);
    endfunction

    function automatic int exp_count(input int t, input int rf, input bit rs);
        return rs ? t % (rf + 1) : t % 65536;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic stop_and_clear(input logic [15:0] rf);
        wr(A_MODE, 16'h0000);
        wr(A_REF, rf);
        wr(A_EVT, 16'h0003);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset reg", v, 16'h0000);
        end
        chk("R1 reset irq", {15'b0, irq}, 16'h0000);

        // R2 readback incl. reserved fields
        wr(A_MODE, 16'hA5E0);
        rd(A_MODE, v); chk("R2 mode readback", v, 16'hA5E0);
        wr(A_REF, 16'hBEEF);
        rd(A_REF, v);  chk("R2 ref readback", v, 16'hBEEF);

        // R3 source off: no counting
        stop_and_clear(16'd5);
        wr(A_MODE, mk_mode(0, 1, 1, 0, 1));
        repeat (50) @(negedge clk);
        rd(A_CNT, v); chk("R3 source off count", v, 16'h0000);

        // R3 external edges
        stop_and_clear(16'hFFFF);
        wr(A_MODE, mk_mode(0, 0, 0, 3, 1));
        for (int k = 0; k < 10; k++) begin
            ext_clk_in = 1'b1; repeat (3) @(negedge clk);
            ext_clk_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R3 external edge count", v, 16'd10);

        // R10 counter write clears
        stop_and_clear(16'hFFFF);
        wr(A_MODE, mk_mode(0, 0, 0, 1, 1));
        repeat (30) @(negedge clk);
        wr(A_CNT, 16'h1234);
        rd(A_CNT, v); chk("R10 count after write", v, 16'h0000);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R10 count resumes", v, 16'd5);

        // R5 stop clears and holds
        wr(A_MODE, mk_mode(0, 0, 0, 1, 0));
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R5 stopped count", v, 16'h0000);

        // R6 restart directed: ref 3, 9 ticks -> 1
        stop_and_clear(16'd3);
        wr(A_MODE, mk_mode(0, 1, 1, 1, 1));
        repeat (9) @(negedge clk);
        rd(A_CNT, v); chk("R6 restart count", v, 16'd1);

        // R8/R9/R11 event handling with timer stopped, enable kept
        wr(A_MODE, mk_mode(0, 1, 1, 1, 0));
        rd(A_EVT, v);  chk("R11 event word", v, 16'h0002);
        chk("R9 irq while flagged", {15'b0, irq}, 16'h0001);
        wr(A_EVT, 16'h0001);
        rd(A_EVT, v);  chk("R8 write 0 keeps flag", v, 16'h0002);
        wr(A_MODE, mk_mode(0, 0, 1, 1, 0));
        chk("R9 irq follows enable", {15'b0, irq}, 16'h0000);
        wr(A_MODE, mk_mode(0, 1, 1, 1, 0));
        chk("R9 irq back with enable", {15'b0, irq}, 16'h0001);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v);  chk("R8 write 1 clears", v, 16'h0000);
        chk("R9 irq after clear", {15'b0, irq}, 16'h0000);

        // R7 disabled match: no flag
        stop_and_clear(16'd4);
        wr(A_MODE, mk_mode(0, 0, 1, 1, 1));
        repeat (20) @(negedge clk);
        rd(A_EVT, v); chk("R7 no flag when disabled", v, 16'h0000);

        // R6 wrap without restart
        stop_and_clear(16'd2);
        wr(A_MODE, mk_mode(0, 1, 0, 1, 1));
        repeat (65541) @(negedge clk);
        rd(A_CNT, v); chk("R6 wrap count", v, 16'd5);

        // R4 R3 R7 R9 random runs
        for (int it = 0; it < 16; it++) begin
            int src, ps, rf, n, t;
            bit rs, ie;
            src = 1 + int'($urandom_range(1, 0));
            ps  = int'($urandom_range(7, 0));
            rf  = int'($urandom_range(40, 1));
            n   = int'($urandom_range(600, 20));
            rs  = 1'($urandom_range(1, 0));
            ie  = 1'($urandom_range(1, 0));
            stop_and_clear(rf[15:0]);
            wr(A_MODE, mk_mode(ps, ie, rs, src, 1));
            repeat (n) @(negedge clk);
            t = exp_ticks(src, ps, n);
            rd(A_CNT, v);
            chk("R4 prescaled count", v, 16'(exp_count(t, rf, rs)));
            rd(A_EVT, v);
            chk("R7 match flag", v, (ie && t >= rf) ? 16'h0002 : 16'h0000);
            chk("R9 irq level", {15'b0, irq}, (ie && t >= rf) ? 16'h0001 : 16'h0000);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule